// File: doc/BRIEF.md
# Neuron Accumulate-Threshold Update Pipeline

This block applies a stream of synapse events to a table of neuron membrane potentials. Each 32-bit synapse word names a target neuron, carries a signed weight and holds an opcode. For each word the block reads the target's potential from a state memory that answers three cycles after the request. It adds the weight and compares the sum with a programmable threshold. It then writes back either the sum or zero, where zero is written when the neuron fires.

The block takes one word per cycle with no stall. Consecutive words may hit the same neuron, so the last three write-backs are held in a short history. A read whose address matches an entry in that history takes the held value in place of the stale memory data. Every write-back appears on an update port. Every firing event appears on a spike port with the neuron ID and a flag that says whether the event goes to the host.

Top module: `nrn_accum_pipe`

## Requirements
- R1: The synapse word carries the opcode in bits [31:29], the target neuron in bits [28:16] and a two's-complement weight in bits [15:0]. The weight is sign-extended to the potential width before the add.
- R2: A word accepted with `syn_valid` high at a clock edge produces exactly one write-back on the update port. The update port is registered three edges later, and `upd_pot` shows the value written. Cycles without an accepted word produce no write-back.
- R3: The new potential is the old potential plus the weight. When that sum is greater than or equal to `thresh` (both signed), the neuron fires and its stored potential becomes 0.
- R4: When the sum is below `thresh`, the sum itself is stored and no spike is emitted.
- R5: `spk_host` is 1 only on a spike caused by opcode 3'b100. Opcode 3'b000 and every other opcode produce internal spikes with `spk_host` 0.
- R6: Words aimed at the same neuron at distances of 1, 2 or 3 cycles, including gapless runs, lose no update. Every word sees the result of all earlier words.
- R7: A neuron that fires more than once within a stream emits a separate spike each time.
- R8: After reset every potential is 0 and every output strobe is low.
- R9: `spk_id` and `upd_id` are the 13-bit target zero-extended to 17 bits. `spk_valid` rises in the same cycle as the write-back it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| syn_valid | input | 1 | Synapse word present this cycle |
| syn_word | input | 32 | Opcode, target and weight |
| thresh | input | 36 | Signed firing threshold |
| upd_valid | output | 1 | Write-back issued |
| upd_id | output | 17 | Neuron written |
| upd_pot | output | 36 | Potential written |
| spk_valid | output | 1 | Neuron fired |
| spk_id | output | 17 | ID of the neuron that fired |
| spk_host | output | 1 | Spike is to be reported to the host |

## Verification
The assertions assume that `thresh` does not change while words are in flight. They also assume that every target is below the table depth, since higher targets alias. The stimulus keeps within both assumptions: it changes the threshold only after four idle cycles, and it aims only at neurons inside the 256-entry table. Within those limits the sweep drives same-neuron pairs at every distance from one to five cycles. It also runs gapless runs and a long pseudo-random mix of targets, gaps, opcodes and signed weights. An arithmetic model in the bench checks each of them.

// File: rtl/nrn_pkg.sv
package nrn_pkg;
   localparam int SYN_W  = 32;
   localparam int OP_W   = 3;
   localparam int TGT_W  = 13;
   localparam int WGT_W  = 16;
   // fixed read latency of the state memory; the forwarding window matches it
   localparam int RD_LAT = 3;

   localparam logic [OP_W-1:0] OPC_ACC  = 3'b000;
   localparam logic [OP_W-1:0] OPC_HOST = 3'b100;

   typedef struct packed {
      logic [OP_W-1:0]  op;
      logic [TGT_W-1:0] tgt;
      logic [WGT_W-1:0] wgt;
   } syn_t;
endpackage

// File: rtl/nrn_state_mem.sv
module nrn_state_mem
   import nrn_pkg::*;
#(
   parameter int POT_W = 36,
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [POT_W-1:0] rd_data,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [POT_W-1:0] wr_data
);
   logic [POT_W-1:0] mem [DEPTH];
   logic [POT_W-1:0] rpipe [RD_LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   always_ff @(posedge clk) rpipe[0] <= mem[rd_idx];

   for (genvar g = 1; g < RD_LAT; g++) begin : g_rd_stage
      always_ff @(posedge clk) rpipe[g] <= rpipe[g-1];
   end

   assign rd_data = rpipe[RD_LAT-1];
endmodule

// File: rtl/nrn_fwd_sel.sv
module nrn_fwd_sel #(
   parameter int POT_W = 36,
   parameter int IDX_W = 8,
   parameter int N     = 3
) (
   input  logic [POT_W-1:0]          mem_data,
   input  logic [IDX_W-1:0]          idx,
   input  logic [N-1:0]              h_v,
   input  logic [N-1:0][IDX_W-1:0]   h_i,
   input  logic [N-1:0][POT_W-1:0]   h_p,
   output logic [POT_W-1:0]          pot
);
   // entry 0 is the newest write; scanning oldest first lets the newest win
   always_comb begin
      pot = mem_data;
      for (int i = N - 1; i >= 0; i--) begin
         if (h_v[i] && (h_i[i] == idx)) pot = h_p[i];
      end
   end
endmodule

// File: rtl/nrn_update.sv
module nrn_update #(
   parameter int POT_W = 36,
   parameter int WGT_W = 16
) (
   input  logic [POT_W-1:0] old_pot,
   input  logic [WGT_W-1:0] wgt,
   input  logic [POT_W-1:0] thr,
   output logic [POT_W-1:0] new_pot,
   output logic             fire
);
   logic signed [POT_W-1:0] wgt_x;
   logic signed [POT_W-1:0] sum;

   always_comb begin
      wgt_x   = POT_W'($signed(wgt));
      sum     = $signed(old_pot) + wgt_x;
      fire    = (sum >= $signed(thr));
      new_pot = fire ? '0 : sum;
   end
endmodule

// File: rtl/nrn_accum_pipe.sv
module nrn_accum_pipe
   import nrn_pkg::*;
#(
   parameter int POT_W = 36,
   parameter int ID_W  = 17,
   parameter int DEPTH = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             syn_valid,
   input  logic [SYN_W-1:0] syn_word,
   input  logic [POT_W-1:0] thresh,
   output logic             upd_valid,
   output logic [ID_W-1:0]  upd_id,
   output logic [POT_W-1:0] upd_pot,
   output logic             spk_valid,
   output logic [ID_W-1:0]  spk_id,
   output logic             spk_host
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DEPTH > (1 << TGT_W)) begin : g_bad_range
      $error("DEPTH exceeds the target field range");
   end
   if (POT_W <= WGT_W) begin : g_bad_pot
      $error("POT_W must exceed the weight width");
   end
   if (ID_W < TGT_W) begin : g_bad_id
      $error("ID_W must hold the target field");
   end

   syn_t              in_w;
   logic [RD_LAT-1:0] st_v;
   syn_t              st_w [RD_LAT];
   syn_t              cur;
   logic [IDX_W-1:0]  cur_idx;
   logic [POT_W-1:0]  mem_q, old_pot, new_pot;
   logic              fire, wr_en;

   logic [RD_LAT-1:0]              h_v;
   logic [RD_LAT-1:0][IDX_W-1:0]   h_i;
   logic [RD_LAT-1:0][POT_W-1:0]   h_p;

   assign in_w    = syn_t'(syn_word);
   assign cur     = st_w[RD_LAT-1];
   assign cur_idx = cur.tgt[IDX_W-1:0];
   assign wr_en   = st_v[RD_LAT-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_v <= '0;
      else        st_v <= {st_v[RD_LAT-2:0], syn_valid};
   end

   always_ff @(posedge clk) st_w[0] <= in_w;
   for (genvar g = 1; g < RD_LAT; g++) begin : g_word_stage
      always_ff @(posedge clk) st_w[g] <= st_w[g-1];
   end

   nrn_state_mem #(.POT_W(POT_W), .DEPTH(DEPTH)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (in_w.tgt[IDX_W-1:0]),
      .rd_data (mem_q),
      .wr_en   (wr_en),
      .wr_idx  (cur_idx),
      .wr_data (new_pot)
   );

   nrn_fwd_sel #(.POT_W(POT_W), .IDX_W(IDX_W), .N(RD_LAT)) u_fwd (
      .mem_data (mem_q),
      .idx      (cur_idx),
      .h_v      (h_v),
      .h_i      (h_i),
      .h_p      (h_p),
      .pot      (old_pot)
   );

   nrn_update #(.POT_W(POT_W), .WGT_W(WGT_W)) u_upd (
      .old_pot (old_pot),
      .wgt     (cur.wgt),
      .thr     (thresh),
      .new_pot (new_pot),
      .fire    (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_v <= '0;
         h_i <= '0;
         h_p <= '0;
      end else begin
         h_v <= {h_v[RD_LAT-2:0], wr_en};
         h_i <= {h_i[RD_LAT-2:0], cur_idx};
         h_p <= {h_p[RD_LAT-2:0], new_pot};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_valid <= 1'b0;
         upd_id    <= '0;
         upd_pot   <= '0;
         spk_valid <= 1'b0;
         spk_id    <= '0;
         spk_host  <= 1'b0;
      end else begin
         upd_valid <= wr_en;
         upd_id    <= ID_W'(cur.tgt);
         upd_pot   <= new_pot;
         spk_valid <= wr_en && fire;
         spk_id    <= ID_W'(cur.tgt);
         spk_host  <= wr_en && fire && (cur.op == OPC_HOST);
      end
   end
endmodule

// File: rtl/nrn_pipe_chk.sv
module nrn_pipe_chk #(
   parameter int POT_W = 36,
   parameter int ID_W  = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             syn_valid,
   input logic [POT_W-1:0] thresh,
   input logic             upd_valid,
   input logic [ID_W-1:0]  upd_id,
   input logic [POT_W-1:0] upd_pot,
   input logic             spk_valid,
   input logic [ID_W-1:0]  spk_id,
   input logic             spk_host
);
   // R2
   wb_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      syn_valid |-> ##4 upd_valid);

   // R2
   wb_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> $past(syn_valid, 4));

   // R3
   spike_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spk_valid |-> (upd_valid && upd_pot == '0));

   // R4
   quiet_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !spk_valid && $stable(thresh)) |-> ($signed(upd_pot) < $signed(thresh)));

   // R5
   host_needs_spike_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spk_host |-> spk_valid);

   // R9
   spike_id_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spk_valid |-> (spk_id == upd_id));
endmodule

bind nrn_accum_pipe nrn_pipe_chk #(.POT_W(POT_W), .ID_W(ID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .syn_valid (syn_valid),
   .thresh    (thresh),
   .upd_valid (upd_valid),
   .upd_id    (upd_id),
   .upd_pot   (upd_pot),
   .spk_valid (spk_valid),
   .spk_id    (spk_id),
   .spk_host  (spk_host)
);

// File: tb/nrn_accum_pipe_tb.sv
module nrn_accum_pipe_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        syn_valid = 1'b0;
   logic [31:0] syn_word = '0;
   logic [35:0] thresh = '0;
   logic        upd_valid, spk_valid, spk_host;
   logic [16:0] upd_id, spk_id;
   logic [35:0] upd_pot;

   nrn_accum_pipe u_dut (
      .clk(clk), .rst_n(rst_n), .syn_valid(syn_valid), .syn_word(syn_word),
      .thresh(thresh), .upd_valid(upd_valid), .upd_id(upd_id), .upd_pot(upd_pot),
      .spk_valid(spk_valid), .spk_id(spk_id), .spk_host(spk_host));

   typedef struct {
      bit              v;
      int              id;
      logic signed [35:0] pot;
      bit              spk;
      bit              host;
      string           tag;
   } exp_t;

   exp_t sh [4];
   logic signed [35:0] refm [256];
   logic signed [35:0] thr_b = '0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic check_out();
      exp_t e = sh[3];
      n_chk++;
      if (e.v) begin
         if (!(upd_valid === 1'b1 && int'(upd_id) == e.id && $signed(upd_pot) == e.pot &&
               spk_valid === e.spk && spk_host === e.host &&
               (!e.spk || int'(spk_id) == e.id))) begin
            n_fail++;
            $display("FAIL %s: got v=%0b id=%0d pot=%0d spk=%0b sid=%0d host=%0b exp v=1 id=%0d pot=%0d spk=%0b host=%0b",
                     e.tag, upd_valid, upd_id, $signed(upd_pot), spk_valid, spk_id, spk_host,
                     e.id, e.pot, e.spk, e.host);
         end
      end else if (upd_valid !== 1'b0 || spk_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R2 idle: got upd_valid=%0b spk_valid=%0b exp 0 0", upd_valid, spk_valid);
      end
   endtask

   task automatic cyc(bit v, logic [2:0] op, int tgt, int w, string tag);
      logic [15:0] wb;
      logic signed [35:0] nv;
      @(negedge clk);
      check_out();
      for (int i = 3; i > 0; i--) sh[i] = sh[i-1];
      wb = w[15:0];
      sh[0].v = v;
      sh[0].tag = tag;
      if (v) begin
         nv = refm[tgt] + 36'($signed(wb));
         sh[0].id = tgt;
         sh[0].spk = (nv >= thr_b);
         sh[0].host = sh[0].spk && (op == 3'b100);
         sh[0].pot = sh[0].spk ? 36'sd0 : nv;
         refm[tgt] = sh[0].pot;
      end
      syn_valid = v;
      syn_word = {op, 13'(tgt), wb};
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 3'b000, 0, 0, "R2");
   endtask

   task automatic set_thr(int val);
      idle(4);
      thr_b = 36'(val);
      thresh = 36'(val);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      for (int i = 0; i < 256; i++) refm[i] = '0;
      for (int i = 0; i < 4; i++) sh[i].v = 0;
      repeat (3) @(negedge clk);
      // R8: outputs low under reset
      n_chk++;
      if (upd_valid !== 1'b0 || spk_valid !== 1'b0 || spk_host !== 1'b0) begin
         n_fail++;
         $display("FAIL R8: got upd=%0b spk=%0b host=%0b exp 0 0 0", upd_valid, spk_valid, spk_host);
      end
      rst_n = 1'b1;
      set_thr(2000);

      // R8: potentials start at zero
      cyc(1, 3'b000, 3, 700, "R8");
      cyc(1, 3'b000, 4, -50, "R8");
      idle(4);

      // R6 R7: gapless run to one neuron, fires every second word
      for (int i = 0; i < 10; i++) cyc(1, 3'b000, 5, 1000, "R6");
      idle(4);
      for (int i = 0; i < 6; i++) cyc(1, 3'b100, 6, 1000, "R7");
      idle(4);

      // R6: same-neuron pairs at distances 1..5
      for (int d = 1; d <= 5; d++) begin
         cyc(1, 3'b000, 7, 300, "R6");
         for (int k = 1; k < d; k++) cyc(1, 3'b000, 8, 11, "R6");
         cyc(1, 3'b000, 7, 300, "R6");
         idle(1);
      end
      idle(4);

      // R1: negative weights and sign extension
      cyc(1, 3'b000, 9, -1000, "R1");
      cyc(1, 3'b000, 9, -32768, "R1");
      cyc(1, 3'b000, 9, 32767, "R1");
      idle(4);

      // R3 R4: threshold equality boundary
      cyc(1, 3'b000, 20, 1999, "R4");
      cyc(1, 3'b000, 20, 1, "R3");
      idle(4);
      set_thr(-5);
      cyc(1, 3'b000, 21, -6, "R4");
      cyc(1, 3'b000, 21, 1, "R3");
      idle(4);
      set_thr(2000);

      // R5: host flag by opcode
      cyc(1, 3'b100, 22, 2500, "R5");
      cyc(1, 3'b000, 23, 2500, "R5");
      cyc(1, 3'b011, 24, 2500, "R5");
      cyc(1, 3'b100, 25, 10, "R5");
      idle(4);

      // R9: largest neuron ID in the table
      cyc(1, 3'b100, 255, 2000, "R9");
      idle(4);

      // R6 R7: pseudo-random mix of targets, gaps, opcodes and weights
      lf = 32'hACE1_2457;
      for (int i = 0; i < 1500; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         if (lf[3:2] == 2'b00) idle(1);
         else cyc(1, lf[4] ? 3'b100 : (lf[5] ? 3'b011 : 3'b000),
                  10 + int'(lf[7:6]), int'(lf[19:8] % 12'd1400) - 300, "R6");
      end
      idle(5);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule